// File: doc/BRIEF.md
# HDLC Receive Deframer

This block takes raw HDLC line data, eight line bits per write, and turns it back into the bytes that were framed. Each written word is walked one line bit at a time, least significant bit first, through an 8-bit window register. While the block is hunting it only watches the window. Once the window holds the flag pattern, decoding starts. In decoding, the zero that follows five ones is dropped, and the surviving bits are packed into bytes, again least significant bit first. A running CRC-16 is kept over the same bits.

The running CRC is reseeded at every flag. The value it held when the flag arrived is latched on `frame_crc`. For a frame that carries a correct frame check sequence, that value is the fixed residue of the code. When seven ones arrive in a row, the block raises an abort pulse and throws away the partial byte. It then hunts again. Pulling the enable low wipes all decoding state.

Flag bits never reach the bytes or the CRC. To make this work, decoded bits pass through a six-bit holding line before they are committed. A flag's leading zero and its five ones are still in that line when the sixth one reveals the flag, so they are dropped there.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset `rx_valid`, `flag_seen` and `abort_seen` are 0, `frame_crc` is FFFFh, and the block is hunting.
- R2: A write with `rx_en` low has no effect: no pulse and no byte appear on the next cycle.
- R3: While hunting, no byte is delivered, whatever the line data.
- R4: `flag_seen` is high for one cycle, in the cycle after a write, when the window became 7Eh at any bit of that write. This includes a flag split across two writes, and the window carries bits over from earlier writes.
- R5: While decoding, a 0 line bit that follows five consecutive 1 bits is deleted. Line bit 0 of `wr_data` is the first on the line, and the first surviving bit becomes bit 0 of the delivered byte.
- R6: The bits of opening and closing flags are never delivered. A frame of N stuffed bytes between two flags delivers exactly those N bytes, in order.
- R7: The CRC runs over the delivered bits only. It uses x^16+x^12+x^5+1 in reflected form (8408h, shifted right) and is seeded with FFFFh. At each flag it is reseeded, and its value just before reseeding is latched on `frame_crc`. A frame whose last two bytes are the complemented CRC, low byte first, latches F0B8h.
- R8: Seven consecutive 1 bits (window equal to FEh with bit 0 masked) raise `abort_seen` in the cycle after the write. Decoding stops, the partial byte is discarded, and no byte is delivered until the next flag.
- R9: Holding `rx_en` low clears the window, the ones count, the partial byte and the decoding state. A flag split by a disabled cycle is not detected.
- R10: `rx_valid` pulses for one cycle, in the cycle after the write that completes a byte, with that byte on `rx_byte`. At most one byte is delivered per write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; low clears decoding state |
| wr_stb | input | 1 | Write strobe for one line word |
| wr_data | input | BITS_PER_WRITE | Raw line bits, bit 0 first on the line |
| rx_byte | output | 8 | Last delivered byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_byte` is new |
| flag_seen | output | 1 | One-cycle pulse: flag pattern matched in the last write |
| abort_seen | output | 1 | One-cycle pulse: seven ones matched in the last write |
| frame_crc | output | 16 | CRC latched at the most recent flag |

## Verification
The hardest situations to reach from the ports are the bit-level ones. One is the flag whose leading zero and first ones were already taken as data candidates. Another is the abort that lands while a byte is half packed. Neither lines up with byte writes. The bench therefore builds whole line streams in software: it stuffs the data, inserts the flags and pads with leading zeros to a write boundary. It sweeps payloads of all-ones, repeated flag values and mixed values over many lengths, so the stuffing falls at every bit offset. The abort stream is chosen so that exactly one byte must come out before the partial byte is discarded. The disabled-split flag test shows that state is cleared, by the flag that fails to appear.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  // line symbol and CRC geometry
  localparam int SYM_W  = 8;
  localparam int CRC_W  = 16;
  // a flag is preceded by a zero and five ones that look like data: hold that many
  localparam int HOLD_D = 6;
  localparam int RUN_W  = 3;
  localparam int HOLD_W = $clog2(HOLD_D + 1);
  localparam int PACK_W = $clog2(SYM_W);

  localparam logic [RUN_W-1:0]  RUN_LIM   = RUN_W'(5);
  localparam logic [RUN_W-1:0]  RUN_SAT   = {RUN_W{1'b1}};
  localparam logic [HOLD_W-1:0] HOLD_FULL = HOLD_W'(HOLD_D);
  localparam logic [PACK_W-1:0] PACK_LAST = PACK_W'(SYM_W - 1);

  localparam logic [SYM_W-1:0] FLAG_PAT   = 8'h7E;
  localparam logic [SYM_W-1:0] ABORT_PAT  = 8'hFE;
  localparam logic [SYM_W-1:0] ABORT_MASK = 8'h01;

  localparam logic [CRC_W-1:0] CRC_POLY_R = 16'h8408;
  localparam logic [CRC_W-1:0] CRC_SEED   = 16'hFFFF;

  typedef struct packed {
    logic [SYM_W-1:0]  win;      // newest line bit at the MSB
    logic [RUN_W-1:0]  run;      // consecutive ones, saturating
    logic [HOLD_D-1:0] hold;     // data candidates awaiting commit
    logic [HOLD_W-1:0] hold_n;
    logic [SYM_W-1:0]  pack;     // byte under assembly
    logic [PACK_W-1:0] pack_n;
    logic [CRC_W-1:0]  crc;
    logic              synced;   // a flag has been seen, decoding
  } rx_state_t;

endpackage

// File: rtl/hdlc_rx_crc_bit.sv
module hdlc_rx_crc_bit #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   POLY = 16'h8408
) (
  input  logic [W-1:0] crc_in,
  input  logic         bit_in,
  output logic [W-1:0] crc_out
);
  logic fb;
  assign fb      = crc_in[0] ^ bit_in;
  assign crc_out = (crc_in >> 1) ^ (fb ? POLY : '0);
endmodule

// File: rtl/hdlc_rx_bit_step.sv
module hdlc_rx_bit_step
  import hdlc_rx_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = CRC_POLY_R,
  parameter logic [CRC_W-1:0] SEED = CRC_SEED
) (
  input  rx_state_t         cur,
  input  logic              bit_in,
  output rx_state_t         nxt,
  output logic              flag_hit,
  output logic              abort_hit,
  output logic              byte_done,
  output logic [SYM_W-1:0]  byte_val,
  output logic [CRC_W-1:0]  crc_at_flag
);
  logic [SYM_W-1:0] win_n;
  logic             pop_bit;
  logic [CRC_W-1:0] crc_adv;
  logic             is_cand;
  logic             pop;

  assign win_n   = {bit_in, cur.win[SYM_W-1:1]};
  assign pop_bit = cur.hold[0];

  hdlc_rx_crc_bit #(.W(CRC_W), .POLY(POLY)) u_crc (
    .crc_in (cur.crc),
    .bit_in (pop_bit),
    .crc_out(crc_adv)
  );

  always_comb begin
    nxt         = cur;
    nxt.win     = win_n;
    flag_hit    = (win_n == FLAG_PAT);
    abort_hit   = ((win_n | ABORT_MASK) == (ABORT_PAT | ABORT_MASK));
    byte_done   = 1'b0;
    byte_val    = {pop_bit, cur.pack[SYM_W-1:1]};
    crc_at_flag = cur.crc;

    // a bit is a data candidate only while the ones run is short
    is_cand = cur.synced && (cur.run < RUN_LIM);
    pop     = is_cand && (cur.hold_n == HOLD_FULL);

    if (bit_in) nxt.run = (cur.run == RUN_SAT) ? RUN_SAT : cur.run + RUN_W'(1);
    else        nxt.run = '0;

    if (is_cand) begin
      nxt.hold = {bit_in, cur.hold[HOLD_D-1:1]};
      if (!pop) nxt.hold_n = cur.hold_n + HOLD_W'(1);
    end

    if (pop) begin
      nxt.crc  = crc_adv;
      nxt.pack = byte_val;
      if (cur.pack_n == PACK_LAST) begin
        byte_done  = 1'b1;
        nxt.pack_n = '0;
      end else begin
        nxt.pack_n = cur.pack_n + PACK_W'(1);
      end
    end

    // sixth one: the held candidates belong to a flag or an abort
    if (bit_in && (cur.run == RUN_LIM)) nxt.hold_n = '0;

    if (flag_hit) begin
      crc_at_flag = nxt.crc;
      nxt.crc     = SEED;
      nxt.synced  = 1'b1;
      nxt.hold_n  = '0;
      nxt.pack_n  = '0;
    end

    if (abort_hit) begin
      nxt.synced = 1'b0;
      nxt.hold_n = '0;
      nxt.pack_n = '0;
    end
  end
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int                 BITS_PER_WRITE = SYM_W,
  parameter logic [CRC_W-1:0]   POLY           = CRC_POLY_R,
  parameter logic [CRC_W-1:0]   SEED           = CRC_SEED
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rx_en,
  input  logic                      wr_stb,
  input  logic [BITS_PER_WRITE-1:0] wr_data,
  output logic [SYM_W-1:0]          rx_byte,
  output logic                      rx_valid,
  output logic                      flag_seen,
  output logic                      abort_seen,
  output logic [CRC_W-1:0]          frame_crc
);
  localparam rx_state_t CLEAR_ST = '{
    win: '0, run: '0, hold: '0, hold_n: '0,
    pack: '0, pack_n: '0, crc: SEED, synced: 1'b0
  };

  rx_state_t              st_q;
  rx_state_t              chain   [BITS_PER_WRITE+1];
  logic [BITS_PER_WRITE-1:0] f_v, a_v, e_v;
  logic [SYM_W-1:0]       byte_v  [BITS_PER_WRITE];
  logic [CRC_W-1:0]       crc_v   [BITS_PER_WRITE];
  logic [SYM_W-1:0]       byte_sel;
  logic [CRC_W-1:0]       crc_sel;

  assign chain[0] = st_q;

  genvar gi;
  generate
    for (gi = 0; gi < BITS_PER_WRITE; gi++) begin : g_step
      hdlc_rx_bit_step #(.POLY(POLY), .SEED(SEED)) u_step (
        .cur        (chain[gi]),
        .bit_in     (wr_data[gi]),
        .nxt        (chain[gi+1]),
        .flag_hit   (f_v[gi]),
        .abort_hit  (a_v[gi]),
        .byte_done  (e_v[gi]),
        .byte_val   (byte_v[gi]),
        .crc_at_flag(crc_v[gi])
      );
    end
  endgenerate

  // the last flag of the write decides the latched CRC
  always_comb begin
    byte_sel = rx_byte;
    crc_sel  = frame_crc;
    for (int i = 0; i < BITS_PER_WRITE; i++) begin
      if (e_v[i]) byte_sel = byte_v[i];
      if (f_v[i]) crc_sel  = crc_v[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= CLEAR_ST;
      rx_byte    <= '0;
      rx_valid   <= 1'b0;
      flag_seen  <= 1'b0;
      abort_seen <= 1'b0;
      frame_crc  <= SEED;
    end else begin
      rx_valid   <= 1'b0;
      flag_seen  <= 1'b0;
      abort_seen <= 1'b0;
      if (!rx_en) begin
        st_q <= CLEAR_ST;
      end else if (wr_stb) begin
        st_q       <= chain[BITS_PER_WRITE];
        rx_valid   <= |e_v;
        flag_seen  <= |f_v;
        abort_seen <= |a_v;
        rx_byte    <= byte_sel;
        frame_crc  <= crc_sel;
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_checker.sv
module hdlc_rx_checker (
  input logic        clk,
  input logic        rst,
  input logic        rx_en,
  input logic        wr_stb,
  input logic        rx_valid,
  input logic        flag_seen,
  input logic        abort_seen,
  input logic [15:0] frame_crc
);
  // R1: reset leaves quiet outputs and a seeded CRC
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!rx_valid && !flag_seen && !abort_seen && frame_crc == 16'hFFFF));

  // R2: no accepted write, no activity on the following cycle
  p_quiet_no_write_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && rx_en) |=> !(rx_valid || flag_seen || abort_seen));

  // R4: a flag pulse follows an accepted write
  p_flag_after_write_r4: assert property (@(posedge clk) disable iff (rst)
    flag_seen |-> $past(wr_stb && rx_en));

  // R10: a byte pulse follows an accepted write
  p_byte_after_write_r10: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(wr_stb && rx_en));

  // R7: the latched CRC moves only together with a flag pulse
  p_crc_on_flag_r7: assert property (@(posedge clk) disable iff (rst)
    !flag_seen |-> $stable(frame_crc));
endmodule

bind hdlc_rx_deframer hdlc_rx_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_en     (rx_en),
  .wr_stb    (wr_stb),
  .rx_valid  (rx_valid),
  .flag_seen (flag_seen),
  .abort_seen(abort_seen),
  .frame_crc (frame_crc)
);

// File: tb/tb_hdlc_rx_deframer.sv
module tb_hdlc_rx_deframer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_en = 1'b0;
  logic        wr_stb = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rx_byte;
  logic        rx_valid;
  logic        flag_seen;
  logic        abort_seen;
  logic [15:0] frame_crc;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_deframer dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .wr_stb(wr_stb), .wr_data(wr_data),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .flag_seen(flag_seen),
    .abort_seen(abort_seen), .frame_crc(frame_crc)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic       sb [0:2047];
  int         nb;
  int         ones_run;
  logic [7:0] rxb [0:63];
  int         nrx;
  int         flag_cnt;
  int         abort_cnt;
  logic [7:0] pay [0:15];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int k = 0; k < 8; k++) begin
      logic fb = r[0] ^ b[k];
      r = r >> 1;
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  task automatic clear_obs();
    nrx = 0; flag_cnt = 0; abort_cnt = 0;
  endtask

  task automatic write_word(input logic [7:0] w);
    wr_stb  = 1'b1;
    wr_data = w;
    @(posedge clk);
    @(negedge clk);
    wr_stb = 1'b0;
    if (rx_valid) begin
      if (nrx < 64) rxb[nrx] = rx_byte;
      nrx++;
    end
    if (flag_seen)  flag_cnt++;
    if (abort_seen) abort_cnt++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic push_raw(input logic b);
    sb[nb] = b;
    nb++;
  endtask

  task automatic push_flag();
    for (int k = 0; k < 8; k++) push_raw(k != 0 && k != 7);
    ones_run = 0;
  endtask

  task automatic push_data(input logic [7:0] b);
    for (int k = 0; k < 8; k++) begin
      push_raw(b[k]);
      if (b[k]) ones_run++; else ones_run = 0;
      if (ones_run == 5) begin
        push_raw(1'b0);
        ones_run = 0;
      end
    end
  endtask

  // leading zero padding brings the stream to a write boundary
  task automatic send_stream();
    int pad = (8 - (nb % 8)) % 8;
    int total = pad + nb;
    for (int w = 0; w < total / 8; w++) begin
      logic [7:0] word;
      for (int k = 0; k < 8; k++) begin
        int idx = w * 8 + k;
        word[k] = (idx < pad) ? 1'b0 : sb[idx - pad];
      end
      write_word(word);
    end
  endtask

  task automatic run_frame(input int n, input int kind, input bit bad);
    logic [15:0] c = 16'hFFFF;
    logic [15:0] fcs;
    logic [15:0] exp_crc;
    int mism = 0;
    for (int i = 0; i < n; i++) begin
      case (kind)
        0: pay[i] = 8'((i * 37 + n * 11 + 5) & 255);
        1: pay[i] = 8'hFF;
        2: pay[i] = 8'h7E;
        default: pay[i] = (i % 2) ? 8'hFE : 8'h3F;
      endcase
      c = crc_byte(c, pay[i]);
    end
    fcs = ~c;
    if (bad) fcs = fcs ^ 16'h0001;
    pay[n]   = fcs[7:0];
    pay[n+1] = fcs[15:8];
    exp_crc = crc_byte(crc_byte(c, pay[n]), pay[n+1]);
    nb = 0; ones_run = 0;
    push_flag();
    for (int i = 0; i < n + 2; i++) push_data(pay[i]);
    push_flag();
    clear_obs();
    send_stream();
    chk(nrx == n + 2, "R6 byte count", nrx, n + 2);
    for (int i = 0; i < n + 2 && i < nrx; i++)
      if (rxb[i] !== pay[i]) mism++;
    chk(mism == 0, "R5 destuffed bytes", mism, 0);
    chk(flag_cnt == 2, "R4 flag pulses", flag_cnt, 2);
    chk(abort_cnt == 0, "R8 no abort in clean frame", abort_cnt, 0);
    if (bad) chk(frame_crc == exp_crc, "R7 latched CRC bad FCS", frame_crc, exp_crc);
    else     chk(frame_crc == 16'hF0B8, "R7 residue good FCS", frame_crc, 16'hF0B8);
  endtask

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    clear_obs();
    idle(3);
    @(negedge clk);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk(!rx_valid && !flag_seen && !abort_seen, "R1 quiet outputs", {rx_valid, flag_seen, abort_seen}, 0);
    chk(frame_crc == 16'hFFFF, "R1 CRC seed", frame_crc, 16'hFFFF);

    // R2 writes ignored while disabled
    rx_en = 1'b0;
    clear_obs();
    write_word(8'h7E);
    write_word(8'hFF);
    write_word(8'hFF);
    chk(flag_cnt == 0 && abort_cnt == 0 && nrx == 0, "R2 disabled writes", flag_cnt + abort_cnt + nrx, 0);

    // R3 hunting delivers nothing
    rx_en = 1'b1;
    clear_obs();
    write_word(8'h00); write_word(8'h0F); write_word(8'h33);
    write_word(8'hAA); write_word(8'h55); write_word(8'h00);
    chk(nrx == 0, "R3 no bytes while hunting", nrx, 0);
    chk(flag_cnt == 0, "R3 no flag in noise", flag_cnt, 0);

    // R4 flag split over two writes
    rx_en = 1'b0; idle(1); rx_en = 1'b1;
    clear_obs();
    write_word(8'hE0);
    chk(flag_cnt == 0, "R4 half flag", flag_cnt, 0);
    write_word(8'h07);
    chk(flag_cnt == 1, "R4 split flag", flag_cnt, 1);

    // R9 disable in the middle clears the window
    rx_en = 1'b0; idle(1); rx_en = 1'b1;
    clear_obs();
    write_word(8'hE0);
    rx_en = 1'b0; idle(1); rx_en = 1'b1;
    write_word(8'h07);
    chk(flag_cnt == 0, "R9 split flag after disable", flag_cnt, 0);

    // R5 R6 R7 R10 frame sweep
    for (int kind = 0; kind < 4; kind++)
      for (int n = 1; n <= 10; n++)
        run_frame(n, kind, (kind == 0) && (n % 2 == 1));

    // R8 abort with a half packed byte
    nb = 0; ones_run = 0;
    push_flag();
    push_data(8'h12);
    push_data(8'h34);
    for (int k = 0; k < 8; k++) push_raw(1'b1);
    clear_obs();
    send_stream();
    chk(abort_cnt >= 1, "R8 abort pulse", abort_cnt, 1);
    chk(nrx == 1, "R8 only completed byte", nrx, 1);
    chk(rxb[0] == 8'h12, "R8 byte before abort", rxb[0], 8'h12);
    write_word(8'h00); write_word(8'h00); write_word(8'h24);
    chk(nrx == 1, "R8 silent until next flag", nrx, 1);
    run_frame(3, 0, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule